// File: doc/BRIEF.md
# Card Presence Debounce and Fault Supervisor

This block watches a smart-card slot on behalf of a card interface controller. It drives one status line to the host: `card_ok` is HIGH only when a card is firmly seated, the supply is good and no hardware fault is active. Card insertion is filtered by a debounce counter that advances on ticks from a slow oscillator. Card removal is acted on at once. While the host holds a session open, any loss of card, supply or hardware health raises a one-cycle emergency deactivation request. The contact sequencing logic downstream consumes that request.

After a deactivation, the status stays LOW until the host closes the session. The block then checks the slot again. If the card is still seated and the fault has gone, the status returns HIGH with no new debounce. This tells the host that the cause was a fault and not a removal. If the card is gone, the block returns to its empty-slot state and a new insertion needs the full debounce interval.

The controller has six states:
- `SUP_NOCARD`: slot empty.
- `SUP_DEBOUNCE`: insertion being filtered.
- `SUP_READY`: card seated, host idle.
- `SUP_SESSION`: host session open.
- `SUP_DEACT`: one cycle, emergency request.
- `SUP_LATCH`: fault held until the host releases the session.

Its transitions are:
- insert: NOCARD to DEBOUNCE.
- bounce: DEBOUNCE to NOCARD.
- settle: DEBOUNCE to READY.
- pull: READY to NOCARD.
- idle-fault: READY to LATCH.
- open: READY to SESSION.
- close: SESSION to READY.
- trip: SESSION to DEACT.
- hold: DEACT to LATCH.
- recover: LATCH to READY.
- vacate: LATCH to NOCARD.

Top module: `card_presence_supervisor`

## Requirements
- R1: While reset is asserted and just after it is released, `card_ok` is 0 and `emerg_deact` is 0, whatever the slot inputs are.
- R2: After `card_det_n` goes 0 (0 = card present), `card_ok` rises only after DEB_TICKS cycles with `slow_tick`=1 have passed while the card is present. The count does not advance on cycles with `slow_tick`=0. One tick short of DEB_TICKS leaves `card_ok` at 0.
- R3: If presence drops at any time during the insertion interval, the count restarts from zero. The next insertion then needs a full DEB_TICKS ticks.
- R4: Every input passes through a two-flop synchronizer. Outside a session, `card_det_n` going to 1 leaves `card_ok` at 1 after the second rising clock edge and drives it to 0 after the third, with no debounce wait.
- R5: If the debounce interval completes while `sess_cmd_n` is 0 (0 = session requested), `card_ok` stays 0 and no request is issued. `card_ok` rises once `sess_cmd_n` returns to 1.
- R6: In a session (`card_ok`=1, `sess_cmd_n`=0), card removal, `hw_fault`=1 or `pwr_ok`=0 issues an `emerg_deact` pulse exactly one clock cycle wide and drives `card_ok` to 0.
- R7: Only one request is issued per session, even if further faults follow in it. Closing a session with no fault issues none.
- R8: After a deactivation, `card_ok` stays 0 while `sess_cmd_n` is 0. It returns to 1 when `sess_cmd_n` goes to 1 with the card still present and no fault, with no new debounce.
- R9: If `hw_fault` is still 1 when the host closes the session, `card_ok` stays 0 until `hw_fault` goes to 0.
- R10: If the card was removed during the session, `card_ok` stays 0 after the session closes. A re-inserted card then needs the full debounce interval.
- R11: `pwr_ok`=0 forces `card_ok` to 0 in every state. After the supply returns, with `sess_cmd_n`=1 and the card present, `card_ok` returns to 1.
- R12: `hw_fault`=1 outside a session drives `card_ok` to 0 with no request. `card_ok` returns to 1 when the fault clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_det_n | input | 1 | Slot switch, 0 = card present (asynchronous) |
| sess_cmd_n | input | 1 | Host session command, 0 = session active (asynchronous) |
| pwr_ok | input | 1 | Supply good flag, 1 = good (asynchronous) |
| hw_fault | input | 1 | Overcurrent or overheating flag, 1 = fault (asynchronous) |
| slow_tick | input | 1 | One-cycle enable from the low-frequency oscillator, synchronous to clk |
| card_ok | output | 1 | Status to host, 1 = card ready, 0 = no card or fault |
| emerg_deact | output | 1 | One-cycle emergency deactivation request |

## Verification
The bench targets four boundaries:

- **Debounce edge.** It checks the insertion at exactly one tick short of the interval and at the full interval. A counter that is off by one, or that counts plain clock cycles, would raise status too early or too late.
- **Bounce restart.** It bounces the contact two ticks before completion. A design that resumes the count instead of restarting it would settle early.
- **Request pulses.** It counts request cycles across repeated faults in one session. Any second pulse or stretched pulse would show up as an extra count.
- **Session close.** It walks the close-of-session re-check in three cases: fault still present, supply still absent, and card gone. A design that skips the re-arm, or re-arms a removed card without a debounce, would raise status at the wrong point.

// File: rtl/cardsup_pkg.sv
package cardsup_pkg;

    typedef enum logic [2:0] {
        SUP_NOCARD   = 3'd0,
        SUP_DEBOUNCE = 3'd1,
        SUP_READY    = 3'd2,
        SUP_SESSION  = 3'd3,
        SUP_DEACT    = 3'd4,
        SUP_LATCH    = 3'd5
    } sup_state_e;

    // bit order of the synchronized input bundle
    localparam int IDX_DET  = 3;
    localparam int IDX_CMD  = 2;
    localparam int IDX_POK  = 1;
    localparam int IDX_FLT  = 0;
    localparam int N_INPUTS = 4;

endpackage

// File: rtl/cardsup_sync.sv
module cardsup_sync #(
    parameter int          WIDTH     = 4,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= RST_VAL;
            end else if (s == 0) begin
                stage_q[s] <= async_in;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/cardsup_debounce.sv
module cardsup_debounce #(
    parameter int DEB_TICKS = 640
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic done
);

    localparam int CW = $clog2(DEB_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DEB_TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done = (cnt_q == LIMIT);

    p_count_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);
    p_no_tick_no_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !tick) |=> $stable(cnt_q));
    p_bounce_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/cardsup_fsm.sv
module cardsup_fsm
    import cardsup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pres,
    input  logic sess,
    input  logic pok,
    input  logic flt,
    input  logic deb_done,
    output logic deb_clear,
    output logic status_ok,
    output logic emerg
);

    sup_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SUP_NOCARD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUP_NOCARD: begin
                if (pres) state_d = SUP_DEBOUNCE;                       // insert
            end
            SUP_DEBOUNCE: begin
                if (!pres)                                state_d = SUP_NOCARD;  // bounce
                else if (deb_done && !sess && pok && !flt) state_d = SUP_READY;  // settle
            end
            SUP_READY: begin
                if (!pres)            state_d = SUP_NOCARD;   // pull
                else if (!pok || flt) state_d = SUP_LATCH;    // idle-fault
                else if (sess)        state_d = SUP_SESSION;  // open
            end
            SUP_SESSION: begin
                if (!pres || !pok || flt) state_d = SUP_DEACT;  // trip
                else if (!sess)           state_d = SUP_READY;  // close
            end
            SUP_DEACT: begin
                state_d = SUP_LATCH;                              // hold
            end
            SUP_LATCH: begin
                if (!sess) begin
                    if (!pres)           state_d = SUP_NOCARD;    // vacate
                    else if (pok && !flt) state_d = SUP_READY;    // recover
                end
            end
            default: state_d = SUP_NOCARD;
        endcase
    end

    always_comb begin
        deb_clear = (state_q != SUP_DEBOUNCE) || !pres;
        status_ok = ((state_q == SUP_READY) || (state_q == SUP_SESSION)) && pok;
        emerg     = (state_q == SUP_DEACT);
    end

    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        emerg |=> !emerg);
    p_pulse_from_session_r7: assert property (@(posedge clk) disable iff (!rst_n)
        emerg |-> ($past(state_q) == SUP_SESSION));
    p_settle_needs_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SUP_READY) && ($past(state_q) == SUP_DEBOUNCE)) |-> $past(deb_done));
    p_latch_until_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SUP_LATCH) && sess) |=> (state_q != SUP_READY));
    p_supply_forces_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pok |-> !status_ok);

endmodule

// File: rtl/card_presence_supervisor.sv
module card_presence_supervisor
    import cardsup_pkg::*;
#(
    parameter int DEB_TICKS   = 640,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_det_n,
    input  logic sess_cmd_n,
    input  logic pwr_ok,
    input  logic hw_fault,
    input  logic slow_tick,
    output logic card_ok,
    output logic emerg_deact
);

    localparam logic [N_INPUTS-1:0] SYNC_RST = N_INPUTS'(4'b1100);

    logic [N_INPUTS-1:0] raw_in, syn_in;
    logic deb_clear, deb_done;

    assign raw_in[IDX_DET] = card_det_n;
    assign raw_in[IDX_CMD] = sess_cmd_n;
    assign raw_in[IDX_POK] = pwr_ok;
    assign raw_in[IDX_FLT] = hw_fault;

    cardsup_sync #(
        .WIDTH  (N_INPUTS),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(raw_in),
        .sync_out(syn_in)
    );

    cardsup_debounce #(
        .DEB_TICKS(DEB_TICKS)
    ) u_deb (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(deb_clear),
        .tick (slow_tick),
        .done (deb_done)
    );

    cardsup_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pres     (!syn_in[IDX_DET]),
        .sess     (!syn_in[IDX_CMD]),
        .pok      (syn_in[IDX_POK]),
        .flt      (syn_in[IDX_FLT]),
        .deb_done (deb_done),
        .deb_clear(deb_clear),
        .status_ok(card_ok),
        .emerg    (emerg_deact)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!card_ok && !emerg_deact));

endmodule

// File: tb/card_presence_supervisor_test.sv
module card_presence_supervisor_test;

    localparam int DEB = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_det_n = 1'b1;
    logic sess_cmd_n = 1'b1;
    logic pwr_ok = 1'b1;
    logic hw_fault = 1'b0;
    logic slow_tick = 1'b0;
    logic card_ok, emerg_deact;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    card_presence_supervisor #(.DEB_TICKS(DEB)) uut (
        .clk(clk), .rst_n(rst_n), .card_det_n(card_det_n), .sess_cmd_n(sess_cmd_n),
        .pwr_ok(pwr_ok), .hw_fault(hw_fault), .slow_tick(slow_tick),
        .card_ok(card_ok), .emerg_deact(emerg_deact)
    );

    always @(posedge clk) if (emerg_deact) pulses <= pulses + 1;

    // row: [10:7] tag, [6] det_n, [5] cmd_n, [4] pwr_ok, [3] hw_fault, [2] exp card_ok, [1:0] exp pulses
    localparam int NROWS = 14;
    localparam logic [10:0] TBL [NROWS] = '{
        {4'd6,  4'b0010, 1'b1, 2'd0},  // R6 open session
        {4'd6,  4'b0011, 1'b0, 2'd1},  // R6 fault in session -> pulse
        {4'd8,  4'b0010, 1'b0, 2'd1},  // R8 latched while session held
        {4'd7,  4'b0011, 1'b0, 2'd1},  // R7 second fault, no second pulse
        {4'd9,  4'b0111, 1'b0, 2'd1},  // R9 closed but fault remains
        {4'd9,  4'b0110, 1'b1, 2'd1},  // R9 fault clears -> high
        {4'd6,  4'b0010, 1'b1, 2'd1},  // R6 new session
        {4'd11, 4'b0000, 1'b0, 2'd2},  // R11 supply loss in session -> pulse
        {4'd11, 4'b0100, 1'b0, 2'd2},  // R11 closed, supply still bad
        {4'd11, 4'b0110, 1'b1, 2'd2},  // R11 supply back -> high
        {4'd12, 4'b0111, 1'b0, 2'd2},  // R12 idle fault, no pulse
        {4'd12, 4'b0110, 1'b1, 2'd2},  // R12 idle fault clears
        {4'd7,  4'b0010, 1'b1, 2'd2},  // R7 session again
        {4'd7,  4'b0110, 1'b1, 2'd2}   // R7 clean close, no pulse
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) slow_tick = 1'b1;
            @(negedge clk) slow_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        // R1 reset state, card already present
        card_det_n = 1'b0;
        cyc(3);
        chk("R1 card_ok in reset", card_ok, 0);
        chk("R1 emerg in reset", emerg_deact, 0);
        @(negedge clk) rst_n = 1'b1;
        cyc(1);
        chk("R1 card_ok after reset", card_ok, 0);

        // R2 no ticks -> no progress
        cyc(50);
        chk("R2 no ticks, still low", card_ok, 0);
        ticks(DEB - 1);
        cyc(3);
        chk("R2 one tick short", card_ok, 0);
        ticks(1);
        cyc(3);
        chk("R2 full interval", card_ok, 1);

        // table walk from READY
        base = pulses;
        for (int r = 0; r < NROWS; r++) begin
            @(negedge clk);
            {card_det_n, sess_cmd_n, pwr_ok, hw_fault} = TBL[r][6:3];
            cyc(6);
            chk($sformatf("R%0d row %0d card_ok", TBL[r][10:7], r), card_ok, TBL[r][2]);
            chk($sformatf("R%0d row %0d pulses", TBL[r][10:7], r), pulses - base, TBL[r][1:0]);
        end

        // R10 removal during a session
        base = pulses;
        @(negedge clk) sess_cmd_n = 1'b0;
        cyc(6);
        chk("R10 session open", card_ok, 1);
        @(negedge clk) card_det_n = 1'b1;
        cyc(6);
        chk("R6 removal in session low", card_ok, 0);
        chk("R6 removal pulse count", pulses - base, 1);
        @(negedge clk) sess_cmd_n = 1'b1;
        cyc(6);
        chk("R10 closed, card gone", card_ok, 0);
        @(negedge clk) card_det_n = 1'b0;
        cyc(8);
        chk("R10 reinsert needs debounce", card_ok, 0);
        ticks(DEB);
        cyc(3);
        chk("R10 reinsert settles", card_ok, 1);

        // R4 idle removal latency
        @(negedge clk) card_det_n = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R4 high after two edges", card_ok, 1);
        @(posedge clk); @(negedge clk);
        chk("R4 low after third edge", card_ok, 0);
        chk("R4 no pulse outside session", pulses - base, 1);

        // R3 bounce restarts the count
        cyc(4);
        @(negedge clk) card_det_n = 1'b0;
        cyc(4);
        ticks(DEB - 2);
        @(negedge clk) card_det_n = 1'b1;
        cyc(4);
        @(negedge clk) card_det_n = 1'b0;
        cyc(4);
        ticks(DEB - 1);
        cyc(3);
        chk("R3 restart, one short", card_ok, 0);
        ticks(1);
        cyc(3);
        chk("R3 restart, full", card_ok, 1);

        // R5 debounce finishing during requested session
        @(negedge clk) card_det_n = 1'b1;
        cyc(6);
        base = pulses;
        @(negedge clk) begin sess_cmd_n = 1'b0; card_det_n = 1'b0; end
        cyc(4);
        ticks(DEB + 2);
        cyc(4);
        chk("R5 held low while session requested", card_ok, 0);
        chk("R5 no request", pulses - base, 0);
        @(negedge clk) sess_cmd_n = 1'b1;
        cyc(4);
        chk("R5 high after release", card_ok, 1);

        // R11 supply drop in idle
        @(negedge clk) pwr_ok = 1'b0;
        cyc(3);
        chk("R11 idle supply loss", card_ok, 0);
        @(negedge clk) pwr_ok = 1'b1;
        cyc(6);
        chk("R11 idle supply back", card_ok, 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule